// File: doc/BRIEF.md
# Port-Loaded Memory Block Mapper

This block sits between an 8-bit CPU bus with a 16-bit address and a 256K physical memory. The CPU's 64K logical space is cut into four 16K windows. The top two address bits pick a window. Each window holds a 4-bit physical block number. The block number, joined to the low fourteen address bits, forms an 18-bit physical address.

Software loads the three lower windows with an output instruction to one of four consecutive I/O ports starting at F0h. The port for window n is F0h+n. An input instruction from the same port reads the current block number back. The top window is fixed to a shared common block, so code and data placed there persist across every remap. After reset the windows hold blocks 0, 1, 2 and 3. Software typically then switches to an application layout of 4, 5, 6 and 3. Spare blocks can be swapped into the lower windows as needed, for example as RAM-disk storage.

A memory request drives a chip select for either the ROM region (the lowest blocks) or the RAM region. A remap is held back until the output cycle's write strobe has ended. An access made during the output cycle still sees the old mapping.

Top module: `port_block_mapper`

## Requirements
- R1: While reset (rstN low) is held, and after it is released, windows 0 to 3 hold physical blocks 0, 1, 2 and 3, and dataOutEn is low.
- R2: physAddr[17:14] equals the block number of the window selected by cpuAddr[15:14], and physAddr[13:0] equals cpuAddr[13:0].
- R3: An I/O write is decoded when iorqN=0, wrN=0 and m1N=1, and cpuAddr[7:0] is F0h, F1h or F2h. It loads dataIn[3:0] into window cpuAddr[1:0]. dataIn[7:4] and cpuAddr[15:8] are ignored.
- R4: A decoded write changes the mapping at the first rising clock edge where the write is no longer decoded. Until that edge, translation uses the previous block number.
- R5: A write with m1N=0, or to a port outside F0h to F3h, changes no window.
- R6: Window 3 always holds block 3. A write to port F3h has no effect.
- R7: When iorqN=0, rdN=0 and m1N=1 with cpuAddr[7:0] in F0h to F3h, dataOutEn is 1. In that case dataOut[3:0] is the block of window cpuAddr[1:0] and dataOut[7:4] is 0. Otherwise dataOutEn is 0 and dataOut is 0.
- R8: When mreqN=0, romCsN is low if the translated block is 0 and ramCsN is low otherwise. When mreqN=1, both are high. The two are never low together.
- R9: Any block from 0 to 15 can be placed in windows 0 to 2, including the application layout 4, 5, 6, 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address bus |
| dataIn | input | 8 | CPU data bus during writes |
| iorqN | input | 1 | I/O request, active low |
| mreqN | input | 1 | Memory request, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| m1N | input | 1 | Opcode-fetch / acknowledge marker, active low |
| dataOut | output | 8 | Read-back data for port reads |
| dataOutEn | output | 1 | High while dataOut should drive the bus |
| physAddr | output | 18 | Translated physical address |
| romCsN | output | 1 | ROM chip select, active low |
| ramCsN | output | 1 | RAM chip select, active low |

## Verification
The hardest case to reach is a memory access to a window while that same window's write strobe is still low. A real CPU never overlaps these two cycles. The stimulus therefore holds mreqN low together with a write to port F1h whose upper address byte falls in window 1. It keeps that overlap for several cycles and then releases the strobe. This shows the old block until the release edge and the new block after it. Ignored writes are also checked: one with m1N low, one to port F3h and one to F4h. For each, the stimulus follows up with port reads and memory accesses in every window.

// File: rtl/port_mapper_pkg.sv
package port_mapper_pkg;
  localparam int SLOTS     = 4;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int BLK_W     = 4;
  localparam int LOG_W     = 16;
  localparam int OFFS_W    = LOG_W - SLOT_W;
  localparam int PHYS_W    = BLK_W + OFFS_W;
  localparam int DATA_W    = 8;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [SLOT_W-1:0] slot_t;

  // strobes from bus control to the mapping datapath
  typedef struct packed {
    logic  commit;
    slot_t wrSlot;
    blk_t  wrBlk;
    logic  rdEn;
    slot_t rdSlot;
  } mapStrobe_t;
endpackage

// File: rtl/port_mapper_ctrl.sv
module port_mapper_ctrl
  import port_mapper_pkg::*;
#(
  parameter logic [7:0] PORT_BASE = 8'hF0
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic       iorqN,
  input  logic       wrN,
  input  logic       rdN,
  input  logic       m1N,
  output mapStrobe_t st
);
  logic portHit, wrNow, wrSeenQ;
  slot_t slotQ;
  blk_t  dataQ;
  logic  unusedHi;

  assign portHit = (ioAddr[7:SLOT_W] == PORT_BASE[7:SLOT_W]);
  assign wrNow   = !iorqN && !wrN && m1N && portHit;
  assign unusedHi = ^dataIn[DATA_W-1:BLK_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSeenQ <= 1'b0;
      slotQ   <= '0;
      dataQ   <= '0;
    end else begin
      wrSeenQ <= wrNow;
      if (wrNow) begin
        slotQ <= ioAddr[SLOT_W-1:0];
        dataQ <= dataIn[BLK_W-1:0];
      end
    end
  end

  always_comb begin
    st.commit = wrSeenQ && !wrNow;
    st.wrSlot = slotQ;
    st.wrBlk  = dataQ;
    st.rdEn   = !iorqN && !rdN && m1N && portHit;
    st.rdSlot = ioAddr[SLOT_W-1:0];
  end

  // R3: a commit only follows a cycle with a qualified write to a mapper port
  commit_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> $past(!iorqN && !wrN && m1N && portHit));

  // R4: no commit while the write strobe is still qualified
  commit_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN && !wrN && m1N && portHit) |-> !st.commit);
endmodule

// File: rtl/port_mapper_dp.sv
module port_mapper_dp
  import port_mapper_pkg::*;
#(
  parameter int ROM_BLOCKS   = 1,
  parameter int COMMON_BLOCK = 3,
  parameter bit LOCK_TOP     = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        st,
  input  logic [LOG_W-1:0]  memAddr,
  input  logic              mreqN,
  output logic [PHYS_W-1:0] physAddr,
  output logic              romCsN,
  output logic              ramCsN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  blk_t [SLOTS-1:0] slotBlk;
  blk_t curBlk;
  logic isRom;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (LOCK_TOP && s == SLOTS-1) begin : g_fixed
      assign slotBlk[s] = blk_t'(COMMON_BLOCK);
    end else begin : g_reg
      blk_t regQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regQ <= blk_t'(s);
        else if (st.commit && st.wrSlot == slot_t'(s))
          regQ <= st.wrBlk;
      end
      assign slotBlk[s] = regQ;
    end
  end

  assign curBlk   = slotBlk[memAddr[LOG_W-1:OFFS_W]];
  assign physAddr = {curBlk, memAddr[OFFS_W-1:0]};
  assign isRom    = int'(curBlk) < ROM_BLOCKS;
  assign romCsN   = !(!mreqN && isRom);
  assign ramCsN   = !(!mreqN && !isRom);

  assign dataOutEn = st.rdEn;
  assign dataOut   = st.rdEn ? {{(DATA_W-BLK_W){1'b0}}, slotBlk[st.rdSlot]} : '0;

  // R8
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~romCsN, ~ramCsN}));

  // R8
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    mreqN |-> (romCsN && ramCsN));

  // R4
  map_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(slotBlk));

  // R7
  rd_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> (dataOut[DATA_W-1:BLK_W] == '0));
endmodule

// File: rtl/port_block_mapper.sv
module port_block_mapper
  import port_mapper_pkg::*;
#(
  parameter logic [7:0] PORT_BASE    = 8'hF0,
  parameter int         ROM_BLOCKS   = 1,
  parameter int         COMMON_BLOCK = 3,
  parameter bit         LOCK_TOP     = 1'b1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  dataIn,
  input  logic        iorqN,
  input  logic        mreqN,
  input  logic        wrN,
  input  logic        rdN,
  input  logic        m1N,
  output logic [7:0]  dataOut,
  output logic        dataOutEn,
  output logic [17:0] physAddr,
  output logic        romCsN,
  output logic        ramCsN
);
  mapStrobe_t st;

  port_mapper_ctrl #(.PORT_BASE(PORT_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(cpuAddr[7:0]), .dataIn(dataIn),
    .iorqN(iorqN), .wrN(wrN), .rdN(rdN), .m1N(m1N), .st(st)
  );

  port_mapper_dp #(
    .ROM_BLOCKS(ROM_BLOCKS), .COMMON_BLOCK(COMMON_BLOCK), .LOCK_TOP(LOCK_TOP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .memAddr(cpuAddr), .mreqN(mreqN),
    .physAddr(physAddr), .romCsN(romCsN), .ramCsN(ramCsN),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: tb/port_block_mapper_bench.sv
module port_block_mapper_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  dataIn = 8'h00;
  logic iorqN = 1'b1, mreqN = 1'b1, wrN = 1'b1, rdN = 1'b1, m1N = 1'b1;
  logic [7:0]  dataOut;
  logic        dataOutEn;
  logic [17:0] physAddr;
  logic        romCsN, ramCsN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int  refMap[4];
  bit  refSeen;
  int  refSlot, refData;

  always #5 clk = ~clk;

  port_block_mapper u_port_block_mapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .dataIn(dataIn),
    .iorqN(iorqN), .mreqN(mreqN), .wrN(wrN), .rdN(rdN), .m1N(m1N),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .physAddr(physAddr),
    .romCsN(romCsN), .ramCsN(ramCsN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: commit when a qualified write ends
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) refMap[i] = i;
      refSeen = 1'b0; refSlot = 0; refData = 0;
    end else begin
      bit wv;
      wv = !iorqN && !wrN && m1N && (cpuAddr[7:0] >= 8'hF0) && (cpuAddr[7:0] <= 8'hF3);
      if (refSeen && !wv && refSlot != 3) refMap[refSlot] = refData;
      refSeen = wv;
      if (wv) begin
        refSlot = cpuAddr[1:0];
        refData = dataIn % 16;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        check("R1 reset read enable", {31'b0, dataOutEn}, 32'd0);
      end else begin
        int blk;
        bit rv;
        blk = refMap[cpuAddr[15:14]];
        check("R2 physAddr", {14'b0, physAddr}, {14'b0, blk[3:0], cpuAddr[13:0]});
        check("R8 romCsN", {31'b0, romCsN}, {31'b0, !(!mreqN && blk == 0)});
        check("R8 ramCsN", {31'b0, ramCsN}, {31'b0, !(!mreqN && blk != 0)});
        rv = !iorqN && !rdN && m1N && (cpuAddr[7:0] >= 8'hF0) && (cpuAddr[7:0] <= 8'hF3);
        check("R7 dataOutEn", {31'b0, dataOutEn}, {31'b0, rv});
        check("R7 dataOut", {24'b0, dataOut}, rv ? refMap[cpuAddr[1:0]] : 32'd0);
      end
    end
  end

  task automatic ioWr(input logic [7:0] port, input logic [7:0] d, input logic m1);
    @(posedge clk); #1;
    cpuAddr = {8'h5A, port}; dataIn = d; m1N = m1; iorqN = 1'b0; wrN = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    wrN = 1'b1; iorqN = 1'b1; m1N = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic ioRd(input logic [7:0] port, input logic m1, output logic [7:0] v, output logic en);
    @(posedge clk); #1;
    cpuAddr = {8'hA5, port}; iorqN = 1'b0; rdN = 1'b0; m1N = m1;
    @(negedge clk);
    v = dataOut; en = dataOutEn;
    @(posedge clk); #1;
    iorqN = 1'b1; rdN = 1'b1; m1N = 1'b1;
  endtask

  task automatic memAt(input logic [15:0] a, output logic [17:0] p, output logic rc, output logic mc);
    @(posedge clk); #1;
    cpuAddr = a; mreqN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    p = physAddr; rc = romCsN; mc = ramCsN;
    @(posedge clk); #1;
    mreqN = 1'b1; rdN = 1'b1;
  endtask

  task automatic expectWin(input string tag, input int slot, input int blk);
    logic [17:0] p; logic rc, mc;
    logic [15:0] a;
    a = {slot[1:0], 14'h1A5C};
    memAt(a, p, rc, mc);
    check(tag, {14'b0, p}, {14'b0, blk[3:0], 14'h1A5C});
  endtask

  task automatic expectPort(input string tag, input logic [7:0] port, input int blk);
    logic [7:0] v; logic en;
    ioRd(port, 1'b1, v, en);
    check(tag, {24'b0, v}, blk);
    check(tag, {31'b0, en}, 32'd1);
  endtask

  initial begin
    logic [7:0] v; logic en;
    logic [17:0] p; logic rc, mc;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: boot layout
    for (int i = 0; i < 4; i++) expectPort("R1 boot readback", 8'hF0 + 8'(i), i);
    for (int i = 0; i < 4; i++) expectWin("R1 boot window", i, i);
    memAt(16'h0100, p, rc, mc);
    check("R8 block 0 uses ROM", {30'b0, rc, mc}, 32'b01);

    // R3: upper data bits ignored
    ioWr(8'hF0, 8'hA4, 1'b1);
    expectPort("R3 load window 0", 8'hF0, 4);
    expectWin("R3 window 0 translation", 0, 4);

    // R4: overlap a memory access on window 1 with its own write cycle
    @(posedge clk); #1;
    cpuAddr = 16'h40F1; dataIn = 8'h05; iorqN = 1'b0; wrN = 1'b0; mreqN = 1'b0;
    @(negedge clk); check("R4 old block while strobe low", {28'b0, physAddr[17:14]}, 32'd1);
    @(posedge clk); #1;
    @(negedge clk); check("R4 old block while strobe low", {28'b0, physAddr[17:14]}, 32'd1);
    @(posedge clk); #1;
    wrN = 1'b1; iorqN = 1'b1;
    @(negedge clk); check("R4 old block before commit edge", {28'b0, physAddr[17:14]}, 32'd1);
    @(posedge clk); #1;
    @(negedge clk); check("R4 new block after release", {28'b0, physAddr[17:14]}, 32'd5);
    @(posedge clk); #1;
    mreqN = 1'b1;

    // R9: application layout 4,5,6,3
    ioWr(8'hF2, 8'h06, 1'b1);
    for (int i = 0; i < 3; i++) expectWin("R9 application layout", i, 4 + i);
    expectWin("R9 common top window", 3, 3);

    // R6: top window locked
    ioWr(8'hF3, 8'h09, 1'b1);
    expectPort("R6 port F3 write ignored", 8'hF3, 3);
    expectWin("R6 top window still block 3", 3, 3);

    // R5: writes with m1N low and to an outside port ignored
    ioWr(8'hF0, 8'h07, 1'b0);
    expectPort("R5 m1N low write ignored", 8'hF0, 4);
    ioWr(8'hF4, 8'h08, 1'b1);
    for (int i = 0; i < 3; i++) expectPort("R5 outside port ignored", 8'hF0 + 8'(i), 4 + i);
    ioRd(8'hF4, 1'b1, v, en);
    check("R7 outside port not driven", {23'b0, en, v}, 32'd0);
    ioRd(8'hF1, 1'b0, v, en);
    check("R7 read with m1N low not driven", {31'b0, en}, 32'd0);

    // R9 / R8: extreme blocks
    ioWr(8'hF2, 8'h0F, 1'b1);
    memAt(16'h8000, p, rc, mc);
    check("R9 block 15 in window 2", {14'b0, p}, {14'b0, 18'h3C000});
    check("R8 block 15 uses RAM", {30'b0, rc, mc}, 32'b10);
    ioWr(8'hF1, 8'h00, 1'b1);
    memAt(16'h7FFF, p, rc, mc);
    check("R8 block 0 in window 1 uses ROM", {14'b0, p, rc, mc}, {14'b0, 18'h03FFF, 2'b01});
    @(negedge clk);
    check("R8 idle selects high", {30'b0, romCsN, ramCsN}, 32'b11);

    // R1: reset mid-run restores boot layout
    @(posedge clk); #1 rstN = 1'b0;
    @(negedge clk);
    check("R1 reset idle selects", {30'b0, romCsN, ramCsN}, 32'b11);
    @(posedge clk); #1 rstN = 1'b1;
    for (int i = 0; i < 4; i++) expectPort("R1 boot after reset", 8'hF0 + 8'(i), i);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule